// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block gives a simple bus slave a way to name itself after it has raised an interrupt. It sits behind a bit-level SMBus/I2C slave front end. That front end supplies one-cycle strobes for SCL rising and falling edges, the sampled SDA level, and start and stop events. The block drives SDA only through an open-drain pull-down.

An alert request sets an internal latch, and the latch pulls the shared ALERT line low. The host answers the interrupt with a receive-byte read to the shared alert response address. Every armed responder acknowledges that header. Each one then shifts out its own 7-bit address, most significant bit first, followed by a 1. Because SDA is a wired-AND, several responders can drive the byte at once, and the one with the lowest address wins bit by bit. A responder that loses releases the bus at once. It keeps its latch, and so keeps ALERT asserted. Only a response that runs through the host acknowledge clock clears the latch. The host can then ask again and collect the next device.

Top module: `alert_resp_responder`

## Requirements
- R1: After reset the SDA pull-down, the ALERT pull-down and the done pulse are all low, and the alert latch is clear.
- R2: A high on alert_set_i sets the latch on the next clock. alert_pd_o equals the latch and stays high until a completed response clears it.
- R3: The block acknowledges a header by pulling SDA low for the ninth bit only under two conditions. The eight sampled header bits, taken MSB first, must be 0001100 followed by the read bit value 1, which is 0x19. The latch must also be set. Any other header, or a clear latch, leaves SDA released for the whole frame.
- R4: After the header acknowledge, the block sends the byte {dev_addr_i, 1'b1} MSB first. For each data bit it updates SDA on the SCL falling strobe, pulling low for a 0 and releasing for a 1. It releases SDA for the host acknowledge bit.
- R5: When the block samples SDA low on a data bit during which it released SDA, it has lost arbitration. It then drives no further bits, raises no done pulse, and keeps the latch set.
- R6: When the host acknowledge bit is sampled after a full data byte sent without loss, resp_done_o pulses high for one cycle and the latch clears. If alert_set_i is high in that same cycle, the latch stays set.
- R7: A stop or a start event received in the middle of a response aborts it. SDA is released on the next cycle, no done pulse is produced, and the latch stays set.
- R8: sda_pd_o is high only while the alert latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen on the bus (one-cycle strobe) |
| stop_i | input | 1 | Stop seen on the bus (one-cycle strobe) |
| scl_rise_i | input | 1 | SCL rising edge strobe; SDA is sampled in this cycle |
| scl_fall_i | input | 1 | SCL falling edge strobe; the SDA drive is updated |
| sda_i | input | 1 | Sampled SDA bus level |
| alert_set_i | input | 1 | Request to set the alert latch |
| dev_addr_i | input | 7 | This device's own 7-bit address |
| sda_pd_o | output | 1 | SDA open-drain pull-down |
| alert_pd_o | output | 1 | ALERT open-drain pull-down |
| resp_done_o | output | 1 | One-cycle pulse when a response completes |

## Verification
The bench builds two instances with the default 7-bit address width and the standard alert response address, and wires their pull-downs with the host's SDA into one wired-AND bus. Both device addresses are driven at run time. This lets the bench place an arbitration loss on the first data bit (0x20 against 0x48) and on the last address bit (0x20 against 0x21), and show in each case that the loser keeps ALERT asserted until a second read collects it. The same setup covers aborts by stop and by repeated start, headers that must be ignored, and a set request that collides with completion.

// File: rtl/ara_pkg.sv
package ara_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HACK_OUT,
    ST_DATA,
    ST_HOST_ACK
  } ara_state_e;
endpackage

// File: rtl/ara_latch.sv
module ara_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;   // set wins over clear
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q && !clr_i |=> q_q);  // R2
  AST_LATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !q_q);  // R6
  AST_LATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_q);  // R2
endmodule

// File: rtl/ara_ctrl.sv
module ara_ctrl
  import ara_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 7,
  parameter logic [ADDR_W-1:0]    ARA_ADDR = 7'b0001100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              armed_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pd_o,
  output logic              done_o
);
  localparam int unsigned TX_W     = ADDR_W + 1;
  localparam int unsigned CNT_W    = $clog2(TX_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TX_W - 1);
  localparam logic [TX_W-1:0]  HDR_RD   = {ARA_ADDR, 1'b1};

  ara_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TX_W-2:0]  hdr_q;
  logic [TX_W-1:0]  tx_q;
  logic             pd_q;
  logic             done_q;
  logic             hdr_hit;

  assign hdr_hit = ({hdr_q, sda_i} == HDR_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      tx_q    <= '0;
      pd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_HDR;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
      end else if (scl_fall_i) begin
        unique case (state_q)
          ST_HACK_OUT: pd_q <= 1'b1;
          ST_DATA:     pd_q <= ~tx_q[TX_W-1];
          default:     pd_q <= 1'b0;
        endcase
      end else if (scl_rise_i) begin
        unique case (state_q)
          ST_HDR: begin
            hdr_q <= {hdr_q[TX_W-3:0], sda_i};
            if (cnt_q == LAST_BIT) begin
              cnt_q   <= '0;
              state_q <= (hdr_hit && armed_i) ? ST_HACK_OUT : ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HACK_OUT: begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            tx_q    <= {dev_addr_i, 1'b1};
          end
          ST_DATA: begin
            if (!pd_q && !sda_i) begin
              // released a 1 but bus reads 0: lost arbitration
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else begin
              tx_q <= {tx_q[TX_W-2:0], 1'b0};
              if (cnt_q == LAST_BIT) begin
                cnt_q   <= '0;
                state_q <= ST_HOST_ACK;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_HOST_ACK: begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o = pd_q;
  assign done_o   = done_q;

  AST_PD_NEEDS_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> armed_i);  // R8
  AST_LOSS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA && scl_rise_i && !scl_fall_i && !start_i && !stop_i
      && !pd_q && !sda_i |=> state_q == ST_IDLE && !done_q);  // R5
  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i || stop_i |=> !pd_q && !done_q);  // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q ##1 done_q |-> $past(state_q == ST_HOST_ACK));  // R6
  AST_RELEASE_HOST_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOST_ACK && !$past(scl_fall_i) && $past(state_q == ST_HOST_ACK) |-> !pd_q);  // R4
endmodule

// File: rtl/alert_resp_responder.sv
module alert_resp_responder #(
  parameter int unsigned       ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              alert_set_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pd_o,
  output logic              alert_pd_o,
  output logic              resp_done_o
);
  logic armed;
  logic done;

  ara_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (alert_set_i),
    .clr_i  (done),
    .q_o    (armed)
  );

  ara_ctrl #(
    .ADDR_W   (ADDR_W),
    .ARA_ADDR (ARA_ADDR)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .scl_rise_i (scl_rise_i),
    .scl_fall_i (scl_fall_i),
    .sda_i      (sda_i),
    .armed_i    (armed),
    .dev_addr_i (dev_addr_i),
    .sda_pd_o   (sda_pd_o),
    .done_o     (done)
  );

  assign alert_pd_o  = armed;
  assign resp_done_o = done;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);  // R6
endmodule

// File: tb/alert_resp_responder_bench.sv
module alert_resp_responder_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, rise = 1'b0, fall = 1'b0;
  logic host_sda = 1'b1;
  logic set_a = 1'b0, set_b = 1'b0;
  logic [6:0] addr_a = 7'h20, addr_b = 7'h48;
  logic pd_a, pd_b, al_a, al_b, dn_a, dn_b;
  logic bus;
  assign bus = host_sda & ~pd_a & ~pd_b;

  alert_resp_responder u_alert_resp_responder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .scl_rise_i(rise), .scl_fall_i(fall), .sda_i(bus),
    .alert_set_i(set_a), .dev_addr_i(addr_a),
    .sda_pd_o(pd_a), .alert_pd_o(al_a), .resp_done_o(dn_a));

  alert_resp_responder u_peer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .scl_rise_i(rise), .scl_fall_i(fall), .sda_i(bus),
    .alert_set_i(set_b), .dev_addr_i(addr_b),
    .sda_pd_o(pd_b), .alert_pd_o(al_b), .resp_done_o(dn_b));

  int tests = 0, fails = 0;
  int dcnt_a = 0, dcnt_b = 0, base_a = 0, base_b = 0;
  always @(posedge clk) begin
    if (dn_a) dcnt_a <= dcnt_a + 1;
    if (dn_b) dcnt_b <= dcnt_b + 1;
  end

  typedef struct {
    string      tag;
    bit         full;
    logic [7:0] rbyte;
    logic       ack;
    logic       al_a;
    logic       al_b;
    int         dn_a;
    int         dn_b;
  } exp_t;
  exp_t sb[$];
  event txn_ev;
  logic [7:0] cap_byte;
  logic       cap_ack;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    @(negedge clk) fall = 1'b1;
    @(negedge clk) fall = 1'b0; host_sda = b;
    @(negedge clk) rise = 1'b1; seen = bus;
    @(negedge clk) rise = 1'b0;
  endtask

  // nbits < 8 aborts the data phase; rs selects repeated start as the abort
  task automatic xfer(input logic [7:0] hdr, input int nbits, input bit rs);
    logic s;
    base_a = dcnt_a; base_b = dcnt_b;
    cap_byte = 8'h00;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 7; i >= 0; i--) bit_xfer(hdr[i], s);
    bit_xfer(1'b1, cap_ack);
    for (int i = 0; i < nbits; i++) begin
      bit_xfer(1'b1, s);
      cap_byte = {cap_byte[6:0], s};
    end
    if (nbits == 8) bit_xfer(1'b1, s);   // host NACK
    else if (rs) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    host_sda = 1'b1;
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive(input string tag, input logic [7:0] hdr, input int nbits, input bit rs,
                       input logic [7:0] rbyte, input logic ack,
                       input logic ea, input logic eb, input int da, input int db);
    exp_t e;
    e.tag = tag; e.full = (nbits == 8); e.rbyte = rbyte; e.ack = ack;
    e.al_a = ea; e.al_b = eb; e.dn_a = da; e.dn_b = db;
    sb.push_back(e);
    xfer(hdr, nbits, rs);
    -> txn_ev;
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(txn_ev);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " ack"}, 32'(cap_ack), 32'(e.ack));
        if (e.full) chk({e.tag, " byte"}, 32'(cap_byte), 32'(e.rbyte));
        chk({e.tag, " alert_a"}, 32'(al_a), 32'(e.al_a));
        chk({e.tag, " alert_b"}, 32'(al_b), 32'(e.al_b));
        chk({e.tag, " done_a"}, 32'(dcnt_a - base_a), 32'(e.dn_a));
        chk({e.tag, " done_b"}, 32'(dcnt_b - base_b), 32'(e.dn_b));
        chk({e.tag, " R8 released"}, 32'({pd_a, pd_b}), 32'h0);
      end
    end
  end

  task automatic pulse_set(input logic a, input logic b);
    @(negedge clk) set_a = a; set_b = b;
    @(negedge clk) set_a = 1'b0; set_b = 1'b0;
  endtask

  localparam logic [7:0] ARA_RD = 8'h19;
  localparam logic [7:0] ARA_WR = 8'h18;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R1 reset pd", 32'({pd_a, pd_b}), 0);
    chk("R1 reset alert", 32'({al_a, al_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done", 32'({dn_a, dn_b}), 0);

    drive("R3 unarmed", ARA_RD, 8, 0, 8'hFF, 1'b1, 0, 0, 0, 0);

    pulse_set(1, 1);
    chk("R2 set a", 32'(al_a), 1);
    chk("R2 set b", 32'(al_b), 1);
    repeat (10) @(negedge clk);
    chk("R2 hold", 32'({al_a, al_b}), 32'h3);

    drive("R5 first-bit loss", ARA_RD, 8, 0, 8'h41, 1'b0, 0, 1, 1, 0);
    drive("R4 peer answers", ARA_RD, 8, 0, 8'h91, 1'b0, 0, 0, 0, 1);

    pulse_set(1, 0);
    drive("R3 other addr", 8'hA1, 8, 0, 8'hFF, 1'b1, 1, 0, 0, 0);
    drive("R3 write bit", ARA_WR, 8, 0, 8'hFF, 1'b1, 1, 0, 0, 0);
    drive("R7 stop abort", ARA_RD, 3, 0, 8'h00, 1'b0, 1, 0, 0, 0);
    drive("R7 rstart abort", ARA_RD, 5, 1, 8'h00, 1'b0, 1, 0, 0, 0);
    drive("R6 complete", ARA_RD, 8, 0, 8'h41, 1'b0, 0, 0, 1, 0);

    addr_b = 7'h21;
    pulse_set(1, 1);
    drive("R5 last-bit loss", ARA_RD, 8, 0, 8'h41, 1'b0, 0, 1, 1, 0);
    drive("R4 odd addr", ARA_RD, 8, 0, 8'h43, 1'b0, 0, 0, 0, 1);

    @(negedge clk) set_a = 1'b1;
    drive("R6 set wins", ARA_RD, 8, 0, 8'h41, 1'b0, 1, 0, 1, 0);
    @(negedge clk) set_a = 1'b0;
    drive("R6 then clears", ARA_RD, 8, 0, 8'h41, 1'b0, 0, 0, 1, 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule